// File: doc/BRIEF.md
# Manchester Receive Decoder with Nibble Assembly

This block sits on the receive side of a 10 Mb/s twisted-pair port. It takes the line as a stream of half-bit samples at 20 MHz, one sample per clock, together with a squelch flag that says a signal is present. It recovers each bit by comparing the two halves of its Manchester cell and packs the bits into 4-bit nibbles. A one-cycle strobe marks each nibble, which in steady reception comes every eight clocks (the 2.5 MHz nibble rate). A data-valid level frames the reception, and a code-error flag marks any nibble that carried a malformed cell.

On squelch the block first finds which of the two possible half-sample pairings carries the bit cells, using the alternating preamble. It then starts nibbles on a preamble one-bit, so preamble nibbles read 0x5. When the start-of-frame pattern (two consecutive ones) appears, it re-aligns the nibble boundary if needed so that the delimiter nibble reads 0xD and the data nibbles that follow are byte-aligned. The end-of-transmission pulse has no mid-cell transition and is recognised from that. It is stripped, together with any incomplete nibble, and never reaches the output.

Top module: `mnz_rx_decoder`

## Requirements
- R1: While reset is asserted and after its release with squelch low, nib_o is 0 and nib_stb_o, dv_o and err_o are 0.
- R2: A cell whose samples are (0,1) decodes as 1 and (1,0) as 0. Bits fill a nibble from bit 0 upward, and each data byte appears as its low nibble first, then its high nibble.
- R3: Reception starts only after 8 consecutive complementary pairs at one pairing while squelch is high. A constant line, or fewer than 8 preamble cells, produces no strobe, and the chosen pairing holds until squelch drops.
- R4: With at least 40 alternating preamble cells (starting with a one) before the delimiter, at least 6 nibbles of value 0x5 are strobed before the 0xD nibble.
- R5: The delimiter pattern 1,0,1,0,1,0,1,1 yields a 0xD nibble whatever the preamble length parity, and data nibbles follow it on byte boundaries.
- R6: From the 0xD nibble onward, strobes are exactly 8 clocks apart, and no two strobes are ever adjacent.
- R7: Two consecutive cells without a mid-cell transition end reception. dv_o falls, no further strobe occurs, and a trailing partial nibble of 1 to 3 bits is discarded.
- R8: A single non-complementary cell followed by a valid one sets err_o for the nibble that holds it, with that bit taken as the second-half sample. All other nibbles have err_o at 0.
- R9: When squelch is low at a clock edge, dv_o and nib_stb_o are 0 after that edge, and the nibbles already delivered are a prefix of the frame.
- R10: After reception has ended, a new frame is ignored until squelch has gone low and high again.
- R11: dv_o rises with the first strobe of a reception and is high at every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit sample clock, one line sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_smp_i | input | 1 | Current half-bit line sample |
| squelch_i | input | 1 | High while a valid signal is present on the line |
| nib_o | output | 4 | Decoded nibble, bit 0 received first |
| nib_stb_o | output | 1 | One-cycle strobe when a new nibble is on nib_o |
| dv_o | output | 1 | High for the duration of a reception |
| err_o | output | 1 | Code error for the nibble on nib_o |

## Verification
The assertions watch, on every cycle, that strobes never come back to back and always fall inside data-valid, that valid data implies a held phase lock, that squelch loss clears data-valid at once, and that the chosen pairing does not move while locked. Only the bench scenarios can show the values themselves: the decoded payload nibbles, the minimum preamble count, the delimiter re-alignment for both preamble parities, the eight-clock spacing, the discarded partial nibble, the error flag landing on the right nibble, and the refusal to restart without a squelch cycle.

// File: rtl/mnz_pkg.sv
package mnz_pkg;

  localparam int NIB_W = 4;
  localparam int CNT_W = $clog2(NIB_W);
  localparam logic [NIB_W-1:0] SFD_NIB = 4'hD;

  typedef enum logic [2:0] {
    PK_IDLE  = 3'd0,
    PK_ALIGN = 3'd1,
    PK_PRE   = 3'd2,
    PK_DATA  = 3'd3,
    PK_DONE  = 3'd4
  } pk_state_t;

endpackage

// File: rtl/mnz_rst_sync.sv
module mnz_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mnz_phase_lock.sv
module mnz_phase_lock #(
  parameter int LOCK_PAIRS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_i,
  input  logic squelch_i,
  output logic locked_o,
  output logic pair_stb_o,
  output logic pair_bit_o,
  output logic pair_ok_o
);

  localparam int RUN_W = $clog2(LOCK_PAIRS + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOCK_PAIRS);
  localparam logic [RUN_W-1:0] RUN_HIT = RUN_W'(LOCK_PAIRS - 1);

  logic prev_q, prev_n;
  logic have_q, have_n;
  logic par_q, par_n;
  logic phase_q, phase_n;
  logic locked_q, locked_n;
  logic comp;
  logic [1:0] hit;

  // a pair is complementary when the earlier sample differs from the current
  assign comp = prev_q ^ sample_i;

  // one run-length counter per candidate pairing
  generate
    for (genvar p = 0; p < 2; p++) begin : g_par
      logic [RUN_W-1:0] run_q, run_n;
      logic mine;

      assign mine = squelch_i && have_q && (par_q == 1'(p));

      always_comb begin
        run_n = run_q;
        if (!squelch_i) begin
          run_n = '0;
        end else if (mine) begin
          if (!comp)                run_n = '0;
          else if (run_q != RUN_MAX) run_n = run_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_n;
      end

      assign hit[p] = mine && comp && (run_q == RUN_HIT);
    end
  endgenerate

  always_comb begin
    prev_n   = prev_q;
    have_n   = have_q;
    par_n    = par_q;
    phase_n  = phase_q;
    locked_n = locked_q;
    if (!squelch_i) begin
      have_n   = 1'b0;
      par_n    = 1'b0;
      locked_n = 1'b0;
    end else begin
      prev_n = sample_i;
      have_n = 1'b1;
      par_n  = ~par_q;
      if (!locked_q && (|hit)) begin
        locked_n = 1'b1;
        phase_n  = hit[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      have_q   <= 1'b0;
      par_q    <= 1'b0;
      phase_q  <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      prev_q   <= prev_n;
      have_q   <= have_n;
      par_q    <= par_n;
      phase_q  <= phase_n;
      locked_q <= locked_n;
    end
  end

  assign locked_o   = locked_q;
  assign pair_stb_o = locked_q && squelch_i && have_q && (par_q == phase_q);
  assign pair_bit_o = sample_i;
  assign pair_ok_o  = comp;

  AST_LOCK_NEEDS_SQ: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> $past(squelch_i));                                  // R3
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && $past(locked_q)) |-> $stable(phase_q));             // R3

endmodule

// File: rtl/mnz_nibble_pack.sv
module mnz_nibble_pack
  import mnz_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             squelch_i,
  input  logic             locked_i,
  input  logic             pair_stb_i,
  input  logic             pair_bit_i,
  input  logic             pair_ok_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             nib_stb_o,
  output logic             dv_o,
  output logic             err_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NIB_W - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(NIB_W / 2 - 1);

  pk_state_t        st_q, st_n;
  logic             hold_bit_q, hold_bit_n;
  logic             hold_bad_q, hold_bad_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [NIB_W-1:0] sh_q, sh_n;
  logic             acc_q, acc_n;
  logic             last_q, last_n;
  logic [NIB_W-1:0] nib_q, nib_n;
  logic             err_q, err_n;
  logic             stb_q, stb_n;
  logic             dv_q, dv_n;
  logic             push;
  logic [NIB_W-1:0] nib_w;
  logic             err_w;
  logic             sfd_hit;

  // candidate nibble with the held bit placed at the current position
  always_comb begin
    nib_w        = sh_q;
    nib_w[cnt_q] = hold_bit_q;
  end

  assign err_w   = acc_q | hold_bad_q;
  assign sfd_hit = (st_q == PK_PRE) && hold_bit_q && last_q && !hold_bad_q;

  always_comb begin
    st_n       = st_q;
    hold_bit_n = hold_bit_q;
    hold_bad_n = hold_bad_q;
    cnt_n      = cnt_q;
    sh_n       = sh_q;
    acc_n      = acc_q;
    last_n     = last_q;
    nib_n      = nib_q;
    err_n      = err_q;
    stb_n      = 1'b0;
    dv_n       = dv_q;
    push       = 1'b0;
    if (!squelch_i || !locked_i) begin
      st_n = PK_IDLE;
      dv_n = 1'b0;
    end else begin
      unique case (st_q)
        PK_IDLE, PK_ALIGN: begin
          st_n = PK_ALIGN;
          if (pair_stb_i && pair_ok_i && pair_bit_i) begin
            st_n       = PK_PRE;
            hold_bit_n = 1'b1;
            hold_bad_n = 1'b0;
            cnt_n      = '0;
            acc_n      = 1'b0;
            last_n     = 1'b0;
          end
        end
        PK_PRE, PK_DATA: begin
          if (pair_stb_i) begin
            if (hold_bad_q && !pair_ok_i) begin
              st_n = PK_DONE;
              dv_n = 1'b0;
            end else begin
              push       = 1'b1;
              hold_bit_n = pair_bit_i;
              hold_bad_n = !pair_ok_i;
            end
          end
        end
        PK_DONE: dv_n = 1'b0;
        default: st_n = PK_IDLE;
      endcase

      if (push) begin
        last_n = hold_bit_q;
        if (sfd_hit && (cnt_q == CNT_HALF)) begin
          // delimiter ended half-way: force the boundary here
          nib_n = SFD_NIB;
          err_n = err_w;
          stb_n = 1'b1;
          dv_n  = 1'b1;
          cnt_n = '0;
          acc_n = 1'b0;
          st_n  = PK_DATA;
        end else if (cnt_q == CNT_LAST) begin
          nib_n = nib_w;
          err_n = err_w;
          stb_n = 1'b1;
          dv_n  = 1'b1;
          cnt_n = '0;
          acc_n = 1'b0;
          if (sfd_hit) st_n = PK_DATA;
        end else begin
          cnt_n = cnt_q + 1'b1;
          sh_n  = nib_w;
          acc_n = err_w;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= PK_IDLE;
      hold_bit_q <= 1'b0;
      hold_bad_q <= 1'b0;
      cnt_q      <= '0;
      sh_q       <= '0;
      acc_q      <= 1'b0;
      last_q     <= 1'b0;
      nib_q      <= '0;
      err_q      <= 1'b0;
      stb_q      <= 1'b0;
      dv_q       <= 1'b0;
    end else begin
      st_q       <= st_n;
      hold_bit_q <= hold_bit_n;
      hold_bad_q <= hold_bad_n;
      cnt_q      <= cnt_n;
      sh_q       <= sh_n;
      acc_q      <= acc_n;
      last_q     <= last_n;
      nib_q      <= nib_n;
      err_q      <= err_n;
      stb_q      <= stb_n;
      dv_q       <= dv_n;
    end
  end

  assign nib_o     = nib_q;
  assign nib_stb_o = stb_q;
  assign dv_o      = dv_q;
  assign err_o     = err_q;

  AST_STB_HAS_DV: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> dv_q);                                                 // R11
  AST_STB_NOT_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);                                               // R6
  AST_ERR_AT_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> stb_q);                                         // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PK_DONE) |-> !dv_q);                                    // R7

endmodule

// File: rtl/mnz_rx_decoder.sv
module mnz_rx_decoder
  import mnz_pkg::*;
#(
  parameter int LOCK_PAIRS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_smp_i,
  input  logic             squelch_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             nib_stb_o,
  output logic             dv_o,
  output logic             err_o
);

  logic rst_sync_n;
  logic locked;
  logic pair_stb;
  logic pair_bit;
  logic pair_ok;

  mnz_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mnz_phase_lock #(.LOCK_PAIRS(LOCK_PAIRS)) u_lock (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sample_i   (line_smp_i),
    .squelch_i  (squelch_i),
    .locked_o   (locked),
    .pair_stb_o (pair_stb),
    .pair_bit_o (pair_bit),
    .pair_ok_o  (pair_ok)
  );

  mnz_nibble_pack u_pack (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .squelch_i  (squelch_i),
    .locked_i   (locked),
    .pair_stb_i (pair_stb),
    .pair_bit_i (pair_bit),
    .pair_ok_i  (pair_ok),
    .nib_o      (nib_o),
    .nib_stb_o  (nib_stb_o),
    .dv_o       (dv_o),
    .err_o      (err_o)
  );

  AST_DV_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dv_o |-> locked);                                                // R3
  AST_SQ_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !squelch_i |=> (!dv_o && !nib_stb_o));                           // R9

endmodule

// File: tb/sim_mnz_rx_decoder.sv
module sim_mnz_rx_decoder;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_smp;
  logic       squelch;
  logic [3:0] nib;
  logic       stb, dv, err;

  always #10 clk = ~clk;

  mnz_rx_decoder u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_smp_i (line_smp),
    .squelch_i  (squelch),
    .nib_o      (nib),
    .nib_stb_o  (stb),
    .dv_o       (dv),
    .err_o      (err)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cap_n = 0;
  int dv_miss = 0;
  logic [3:0] cap_nib [0:255];
  logic       cap_err [0:255];
  int         cap_cyc [0:255];
  logic [7:0] pay [0:15];
  bit done_flag = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // capture every strobe away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (stb) begin
      if (cap_n < 256) begin
        cap_nib[cap_n] = nib;
        cap_err[cap_n] = err;
        cap_cyc[cap_n] = cyc;
      end
      cap_n++;
      if (!dv) dv_miss++;
    end
    if (cyc > 150000 && !done_flag) begin
      done_flag = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic half(input logic v);
    @(negedge clk);
    line_smp = v;
  endtask

  task automatic mbit(input logic b);
    half(~b);
    half(b);
  endtask

  // expected data nibble j, with an optional malformed bit at data index epos
  function automatic logic [3:0] exp_nib(input int j, input int epos, input logic ev);
    logic [7:0] by;
    logic [3:0] n;
    by = pay[j / 2];
    n  = (j % 2 == 0) ? by[3:0] : by[7:4];
    if (epos >= 0 && epos / 4 == j) n[epos % 4] = ev;
    return n;
  endfunction

  // preamble, delimiter, data, tail and end pulse; squelch stays as it is
  task automatic body(input int pre, input int nb, input int epos, input logic ev,
                      input int tail, input int cut);
    for (int i = 0; i < pre; i++) mbit(logic'(i % 2 == 0));
    for (int i = 0; i < 8; i++) mbit(logic'((i % 2 == 0) || (i == 7)));
    for (int i = 0; i < nb * 8; i++) begin
      if (i == cut) begin
        @(negedge clk);
        squelch = 1'b0;
        return;
      end
      if (i == epos) begin
        half(ev);
        half(ev);
      end else begin
        mbit(pay[i / 8][i % 8]);
      end
    end
    for (int i = 0; i < tail; i++) mbit(logic'($urandom_range(0, 1)));
    repeat (4) half(1'b1);
    repeat (6) half(1'b0);
  endtask

  task automatic frame(input int k, input int pre, input int nb, input int epos,
                       input logic ev, input int tail, input int cut);
    cap_n   = 0;
    dv_miss = 0;
    @(negedge clk);
    squelch  = 1'b1;
    line_smp = 1'b0;
    repeat (k - 1) half(1'b0);
    body(pre, nb, epos, ev, tail, cut);
    if (cut >= 0) begin
      @(negedge clk);
      chk(!dv && !stb, "R9 squelch drop clears", {30'd0, dv, stb}, 0);
    end else begin
      chk(!dv, "R7 dv low after end pulse", int'(dv), 0);
      @(negedge clk);
      squelch = 1'b0;
    end
    repeat (10) half(1'b0);
  endtask

  task automatic analyze(input int nb, input int epos, input logic ev, input int cut);
    int p;
    int lim;
    p = 0;
    while (p < cap_n && cap_nib[p] == 4'h5) p++;
    chk(p >= 6, "R4 preamble nibble count", p, 6);
    chk(p < cap_n && cap_nib[p] == 4'hD, "R5 delimiter nibble", int'(cap_nib[p]), 13);
    chk(dv_miss == 0, "R11 dv at every strobe", dv_miss, 0);
    lim = cap_n - p - 1;
    if (cut < 0) chk(lim == nb * 2, "R7 data nibble count", lim, nb * 2);
    else         chk(lim <= nb * 2, "R9 prefix length", lim, nb * 2);
    if (lim > nb * 2) lim = nb * 2;
    for (int j = 0; j < lim; j++) begin
      logic [3:0] e;
      logic       ef;
      e  = exp_nib(j, epos, ev);
      ef = (epos >= 0) && (epos / 4 == j);
      chk(cap_nib[p + 1 + j] == e, "R2 data nibble", int'(cap_nib[p + 1 + j]), int'(e));
      chk(cap_err[p + 1 + j] == ef, "R8 error flag", int'(cap_err[p + 1 + j]), int'(ef));
      chk(cap_cyc[p + 1 + j] - cap_cyc[p + j] == 8, "R6 strobe spacing",
          cap_cyc[p + 1 + j] - cap_cyc[p + j], 8);
    end
  endtask

  initial begin
    void'($urandom(32'h00C0_FFEE));
    rst_n    = 1'b0;
    squelch  = 1'b0;
    line_smp = 1'b0;
    repeat (4) @(negedge clk);
    chk(nib == 4'h0 && !stb && !dv && !err, "R1 state in reset", {24'd0, nib, stb, dv, err, 1'b0}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(nib == 4'h0 && !stb && !dv && !err, "R1 state after release", {24'd0, nib, stb, dv, err, 1'b0}, 0);

    // R3: constant line and a too-short preamble never start reception
    cap_n = 0;
    @(negedge clk);
    squelch = 1'b1;
    repeat (60) half(1'b1);
    for (int i = 0; i < 7; i++) mbit(logic'(i % 2 == 0));
    repeat (60) half(1'b0);
    @(negedge clk);
    squelch = 1'b0;
    repeat (6) half(1'b0);
    chk(cap_n == 0, "R3 no strobe without lock", cap_n, 0);

    // directed: both delimiter alignments, both pairings, partial tails
    for (int i = 0; i < 4; i++) pay[i] = 8'(8'hA7 + 8'(i * 37));
    frame(1, 56, 4, -1, 1'b0, 0, -1);  analyze(4, -1, 1'b0, -1);
    frame(2, 42, 4, -1, 1'b0, 3, -1);  analyze(4, -1, 1'b0, -1);
    frame(3, 40, 3, 9, 1'b1, 1, -1);   analyze(3, 9, 1'b1, -1);
    frame(4, 54, 2, 0, 1'b0, 2, -1);   analyze(2, 0, 1'b0, -1);

    // R9: squelch lost in the middle of the data
    for (int i = 0; i < 6; i++) pay[i] = 8'($urandom_range(0, 255));
    frame(1, 48, 6, -1, 1'b0, 0, 21);  analyze(6, -1, 1'b0, 21);

    // R10: after an end pulse, a second frame with squelch still high is ignored
    for (int i = 0; i < 3; i++) pay[i] = 8'($urandom_range(0, 255));
    cap_n = 0;
    @(negedge clk);
    squelch  = 1'b1;
    line_smp = 1'b0;
    body(50, 3, -1, 1'b0, 0, -1);
    cap_n = 0;
    repeat (8) half(1'b0);
    body(50, 3, -1, 1'b0, 0, -1);
    chk(cap_n == 0, "R10 no restart without squelch cycle", cap_n, 0);
    @(negedge clk);
    squelch = 1'b0;
    repeat (6) half(1'b0);
    frame(2, 50, 3, -1, 1'b0, 1, -1);  analyze(3, -1, 1'b0, -1);

    // constrained random frames
    for (int n = 0; n < 12; n++) begin
      int k, pre, nb, ep, tl;
      logic ev;
      k   = $urandom_range(1, 4);
      pre = 2 * $urandom_range(20, 28);
      nb  = $urandom_range(1, 8);
      for (int i = 0; i < nb; i++) pay[i] = 8'($urandom_range(0, 255));
      ep  = ($urandom_range(0, 1) == 1) ? $urandom_range(0, nb * 8 - 2) : -1;
      ev  = logic'($urandom_range(0, 1));
      tl  = $urandom_range(0, 3);
      frame(k, pre, nb, ep, ev, tl, -1);
      analyze(nb, ep, ev, -1);
    end

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule